// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block issues Clause 22 management transactions to external Ethernet PHYs. A single request port takes a read or write command, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block builds the serial frame, drives it on the data line while toggling the management clock, and releases the data line wherever the PHY is the one that drives it. For reads, it shifts in the value returned by the PHY.

Each MDC bit period is a low phase followed by a high phase, and both phases last the same number of system clocks, set by one parameter. A run of 32 ones, the preamble, can be sent ahead of the frame. Some PHYs ignore a frame that has no preamble, so the preamble is normally enabled. After the last data bit, MDC is held low with the data line released for a settling time so the external pull-up can restore the line. One more low-then-high MDC pulse then ends the transaction, and a one-cycle `done` pulse reports completion. Between transactions MDC rests high.

Top module: `mdio_master`

## Requirements
- R1: A write sends, MSB first after any preamble, start bits 0 then 1, opcode 0 then 1, the PHY address, the register address, turnaround 1 then 0, and the 16 write-data bits, with `mdio_oe` high for all of them.
- R2: A read sends start 0,1, opcode 1,0, the PHY address and the register address with `mdio_oe` high. It then holds `mdio_oe` low for both turnaround bits, all 16 data bits and everything up to the end of the transaction.
- R3: When `pre_en` is 1 at the `go` cycle, 32 bits of value 1 precede the start bits. When it is 0, the first bit sent is the start bit 0.
- R4: Inside the frame, each MDC low phase and each MDC high phase lasts exactly HALF_CLKS system clocks. MDC changes level only at a phase boundary or when a request is accepted.
- R5: The master changes `mdio_o` and `mdio_oe` only together with a falling MDC edge, and samples `mdio_i` at each rising MDC edge. On completion of a read, `rd_data` holds the 16 sampled data bits, MSB first. A write leaves `rd_data` unchanged.
- R6: After the falling edge that follows the last data bit, MDC stays low and `mdio_oe` stays low for SETTLE_CLKS + HALF_CLKS system clocks before MDC rises again.
- R7: Exactly one extra rising MDC edge follows the last data bit, so a frame of N bits produces N+1 rising edges.
- R8: `done` is high for exactly one system clock, HALF_CLKS clocks after the extra rising edge, and `busy` is low in that cycle.
- R9: A `go` pulse while `busy` is high is ignored. The transaction in progress and its bits are unchanged, and only one `done` follows.
- R10: After reset and between transactions, `mdc` is 1, `mdio_oe` is 0 and `busy` is 0. After reset, `done` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a transaction when idle |
| is_read | input | 1 | 1 = register read, 0 = register write |
| pre_en | input | 1 | Send 32-bit preamble of ones |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last value read from a PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions check these rules on every cycle: the idle line state, the length of the `done` pulse and that it never comes while `busy` is high, that MDC changes only at phase boundaries, that the data line is released during the settle window and during the PHY-driven part of a read, and that the latched request does not change under a `go` that arrives while busy. Only the bench scenarios can show the rest, using a PHY model that samples the line on each MDC rise and answers reads. These are the exact bit order of each frame with and without preamble, the turnaround values, the phase widths and settle span in time, the count of trailing edges, and the value returned in `rd_data`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FRAME, ST_SETTLE, ST_TAIL_LO, ST_TAIL_HI
  } mdio_state_e;

  localparam int PRE_LEN = 32;
  localparam int HDR_TA  = 14;   // frame index of first turnaround bit

  // 32-bit Clause 22 frame after the preamble, MSB sent first.
  // For reads the turnaround and data fields are placeholders (line released).
  function automatic logic [31:0] frame_bits(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {2'b01, op, phy, ra, ta, rd ? 16'hFFFF : wd};
  endfunction

  // Full shift image, left aligned.
  function automatic logic [63:0] shift_image(input logic pre, input logic [31:0] fr);
    return pre ? {32'hFFFF_FFFF, fr} : {fr, 32'h0};
  endfunction

  function automatic logic [6:0] bit_total(input logic pre);
    return pre ? 7'd64 : 7'd32;
  endfunction

  // First bit index at which a read releases the line.
  function automatic logic [6:0] release_at(input logic pre);
    return pre ? 7'(PRE_LEN + HDR_TA) : 7'(HDR_TA);
  endfunction
endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          ph_end
);
  logic [CW-1:0] cnt;

  assign ph_end = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || ph_end)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        is_read,
  input  logic        pre_en,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        mdio_i,
  input  logic        ph_end,
  output mdio_state_e state,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [9:0]  req_tag,
  output logic        rd_zone
);
  logic [63:0] tx_q;
  logic [15:0] rx_q;
  logic [6:0]  idx_q;
  logic        rd_q;
  logic        pre_q;
  logic [6:0]  nxt;
  logic [63:0] img;

  assign nxt     = idx_q + 7'd1;
  assign img     = shift_image(pre_en, frame_bits(is_read, phy_addr, reg_addr, wr_data));
  assign rd_zone = (state == ST_FRAME) && rd_q && (idx_q >= release_at(pre_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      rd_data <= '0;
      mdc     <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      pre_q   <= 1'b0;
      req_tag <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) begin
          state   <= ST_FRAME;
          rd_q    <= is_read;
          pre_q   <= pre_en;
          req_tag <= {phy_addr, reg_addr};
          idx_q   <= '0;
          mdc     <= 1'b0;
          mdio_o  <= img[63];
          mdio_oe <= 1'b1;
          tx_q    <= img << 1;
        end
        ST_FRAME: if (ph_end) begin
          if (!mdc) begin
            mdc  <= 1'b1;
            rx_q <= {rx_q[14:0], mdio_i};
          end else begin
            mdc   <= 1'b0;
            idx_q <= nxt;
            if (nxt == bit_total(pre_q)) begin
              state   <= ST_SETTLE;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
            end else begin
              mdio_o  <= tx_q[63];
              tx_q    <= tx_q << 1;
              mdio_oe <= !(rd_q && (nxt >= release_at(pre_q)));
            end
          end
        end
        ST_SETTLE:  if (ph_end) state <= ST_TAIL_LO;
        ST_TAIL_LO: if (ph_end) begin
          state <= ST_TAIL_HI;
          mdc   <= 1'b1;
        end
        ST_TAIL_HI: if (ph_end) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          if (rd_q) rd_data <= rx_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CLKS   = 4,
  parameter int SETTLE_CLKS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        is_read,
  input  logic        pre_en,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int MAXL = (HALF_CLKS > SETTLE_CLKS) ? HALF_CLKS : SETTLE_CLKS;
  localparam int CW   = $clog2(MAXL + 1);

  mdio_state_e   state;
  logic          ph_end;
  logic          in_settle;
  logic          rd_zone;
  logic [9:0]    req_tag;
  logic [CW-1:0] limit;

  assign busy      = (state != ST_IDLE);
  assign in_settle = (state == ST_SETTLE);
  assign limit     = in_settle ? CW'(SETTLE_CLKS - 1) : CW'(HALF_CLKS - 1);

  mdio_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .limit(limit), .ph_end(ph_end)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .is_read(is_read), .pre_en(pre_en),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .mdio_i(mdio_i), .ph_end(ph_end), .state(state), .done(done),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .req_tag(req_tag), .rd_zone(rd_zone)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       busy,
  input logic       done,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       ph_end,
  input logic       in_settle,
  input logic       rd_zone,
  input logic [9:0] req_tag
);
  p_idle_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe));

  p_mdc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> ($past(ph_end) || $past(go && !busy)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_settle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |-> (!mdc && !mdio_oe));

  p_read_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zone |-> !mdio_oe);

  p_busy_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> $stable(req_tag));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .mdc(mdc),
  .mdio_oe(mdio_oe), .ph_end(ph_end), .in_settle(in_settle),
  .rd_zone(rd_zone), .req_tag(req_tag)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int PERIOD = 10;
  localparam int HALF   = 4;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, is_read = 1'b0, pre_en = 1'b1;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic phy_en = 1'b0, phy_bit = 1'b1;
  wire  mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  always #(PERIOD/2) clk = ~clk;

  mdio_master #(.HALF_CLKS(HALF), .SETTLE_CLKS(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .is_read(is_read), .pre_en(pre_en),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  int checks = 0, errors = 0;
  logic mon = 1'b0, cur_rd = 1'b0, cur_pre = 1'b0;
  logic [15:0] cur_d = '0;
  logic [64:0] cap, oecap;
  int rises, done_clks;
  time t_fall0, t_rise0, t_fall1, t_last_fall, t_last_rise;

  // {rd, pre, phy[4:0], reg[4:0], data[15:0]} : data is write value or PHY reply
  localparam logic [27:0] VEC [0:5] = '{
    {1'b0, 1'b1, 5'd3,  5'd4,  16'hA5C3},
    {1'b1, 1'b1, 5'd1,  5'd2,  16'h1234},
    {1'b0, 1'b0, 5'd17, 5'd9,  16'h0F0F},
    {1'b1, 1'b0, 5'd30, 5'd21, 16'hBEEF},
    {1'b0, 1'b1, 5'd31, 5'd31, 16'hFFFF},
    {1'b1, 1'b0, 5'd0,  5'd0,  16'h0001}
  };

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge mdc) if (mon) begin
    cap   = {cap[63:0], mdio_line};
    oecap = {oecap[63:0], mdio_oe};
    if (rises == 0) t_rise0 = $time;
    t_last_rise = $time;
    rises++;
  end

  always @(negedge mdc) begin
    int f;
    if (mon) begin
      if (rises == 0) t_fall0 = $time;
      if (rises == 1) t_fall1 = $time;
      t_last_fall = $time;
      f = rises - (cur_pre ? 32 : 0);
      if (cur_rd && f >= 15 && f <= 31) begin
        phy_en  = 1'b1;
        phy_bit = (f == 15) ? 1'b0 : cur_d[31-f];
      end else phy_en = 1'b0;
    end else phy_en = 1'b0;
  end

  always @(posedge clk) if (mon && done) done_clks++;

  // Expected bit stream and output-enable pattern, built bit by bit.
  task automatic expect_frame(input logic rd, input logic pre, input logic [4:0] pa,
                              input logic [4:0] ra, input logic [15:0] d,
                              output logic [64:0] eb, output logic [64:0] eo, output int n);
    eb = '0; eo = '0; n = 0;
    if (pre) for (int i = 0; i < 32; i++) begin eb = {eb[63:0], 1'b1}; eo = {eo[63:0], 1'b1}; n++; end
    eb = {eb[62:0], 2'b01}; eo = {eo[62:0], 2'b11}; n += 2;
    eb = {eb[62:0], rd ? 2'b10 : 2'b01}; eo = {eo[62:0], 2'b11}; n += 2;
    for (int i = 4; i >= 0; i--) begin eb = {eb[63:0], pa[i]}; eo = {eo[63:0], 1'b1}; n++; end
    for (int i = 4; i >= 0; i--) begin eb = {eb[63:0], ra[i]}; eo = {eo[63:0], 1'b1}; n++; end
    eb = {eb[62:0], 2'b10}; eo = {eo[62:0], rd ? 2'b00 : 2'b11}; n += 2;
    for (int i = 15; i >= 0; i--) begin eb = {eb[63:0], d[i]}; eo = {eo[63:0], !rd}; n++; end
    eb = {eb[63:0], 1'b1}; eo = {eo[63:0], 1'b0};   // trailing pulse, line released
  endtask

  logic [15:0] last_rd = '0;

  task automatic run(input logic rd, input logic pre, input logic [4:0] pa,
                     input logic [4:0] ra, input logic [15:0] d, input bit glitch);
    logic [64:0] eb, eo;
    int n;
    cur_rd = rd; cur_pre = pre; cur_d = d;
    cap = '0; oecap = '0; rises = 0; done_clks = 0; mon = 1'b1;
    @(negedge clk);
    is_read = rd; pre_en = pre; phy_addr = pa; reg_addr = ra; wr_data = d; go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (glitch) begin
      repeat (100) @(negedge clk);
      chk("R9 busy during frame", {64'd0, busy}, 65'd1);
      is_read = ~rd; pre_en = ~pre; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~d; go = 1'b1;
      @(negedge clk); go = 1'b0;
    end
    @(posedge done);
    repeat (3) @(negedge clk);
    mon = 1'b0;
    expect_frame(rd, pre, pa, ra, d, eb, eo, n);
    chk(rd ? "R2 R3 read bits" : "R1 R3 write bits", cap, eb);
    chk("R2 R5 output enable pattern", oecap, eo);
    chk("R7 rising edge count", 65'(rises), 65'(n + 1));
    chk("R8 done width", 65'(done_clks), 65'd1);
    chk("R4 first low phase", 65'(t_rise0 - t_fall0), 65'(HALF * PERIOD));
    chk("R4 first high phase", 65'(t_fall1 - t_rise0), 65'(HALF * PERIOD));
    chk("R6 settle low span", 65'(t_last_rise - t_last_fall), 65'((SETTLE + HALF) * PERIOD));
    if (rd) last_rd = d;
    chk("R5 rd_data", {49'd0, rd_data}, {49'd0, last_rd});
    chk("R10 idle after", {62'd0, mdc, mdio_oe, busy}, {62'd0, 3'b100});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: done not reached actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", {60'd0, mdc, mdio_oe, busy, done, 1'b0}, {60'd0, 5'b10000});
    chk("R10 reset rd_data", {49'd0, rd_data}, 65'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle after reset", {62'd0, mdc, mdio_oe, busy}, {62'd0, 3'b100});
    for (int i = 0; i < 6; i++) begin
      logic [27:0] v;
      v = VEC[i];
      run(v[27], v[26], v[25:21], v[20:16], v[15:0], 1'b0);
    end
    // R9: request while busy must not alter the frame in progress
    run(1'b0, 1'b1, 5'd5, 5'd6, 16'h5A5A, 1'b1);
    run(1'b1, 1'b1, 5'd9, 5'd12, 16'hC001, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule